// File: doc/BRIEF.md
# PLL Frequency Lock and Bandwidth Detector

This block watches a phase-locked loop from the digital side. Two enable pulses arrive in the system clock domain: one per period of the divided reference clock, and one per period of the divided VCO feedback clock. The detector opens a measurement window that spans a fixed number of reference pulses and counts the feedback pulses that fall inside it. The distance between that count and the window length is the frequency error for the window. Because a window always spans the same number of reference pulses, decisions arrive at a rate that scales with the reference frequency.

From each window's error the block keeps two flags. Each flag has its own hysteresis band, so it sets at a small error and clears only at a larger one. The mode flag tells the loop filter whether to run in acquisition (wide bandwidth, large corrections) or tracking (narrow bandwidth, small corrections). The lock flag reports that the loop has settled, and each change of the lock flag can raise a sticky interrupt request. With automatic control off, the mode follows a manual request instead of the measurements.

Top module: `pll_lock_bw_detect`

## Requirements
- R1: After reset, `trk_mode`, `locked`, `bw_narrow` and `irq` are all 0, which puts the filter in acquisition mode.
- R2: A window closes on the `WIN_REFS`-th `ref_pulse` since the previous close. Its error is |F − `WIN_REFS`|, where F is the number of `fb_pulse` cycles in the window, including the closing cycle. Both flags change only as a result of a closed window, or of the manual request in R9.
- R3: In automatic mode (`auto_en`=1), `trk_mode` becomes 1 after a window whose error is at most `TRK_ENTER`.
- R4: In automatic mode, `trk_mode` becomes 0 after a window whose error exceeds `TRK_EXIT`. An error above `TRK_ENTER` and at most `TRK_EXIT` leaves it unchanged.
- R5: `locked` becomes 1 after a window whose error is at most `LOCK_ENTER`. In automatic mode this happens only if `trk_mode` was already 1 before that window closed.
- R6: `locked` becomes 0 after a window whose error exceeds `UNLOCK`. An error above `LOCK_ENTER` and at most `UNLOCK` leaves it unchanged.
- R7: With `irq_en`=1, every change of `locked`, rising or falling, sets `irq`. With `irq_en`=0, a change of `locked` leaves `irq` at 0.
- R8: Once set, `irq` stays at 1 until a one-cycle `irq_ack`. If a new change arrives in the same cycle as the acknowledge, the request stays set.
- R9: With `auto_en`=0, `trk_mode` takes the value of `manual_trk` one cycle later, and closed windows do not alter it. In this mode `locked` sets without any condition on `trk_mode`.
- R10: `bw_narrow` equals `trk_mode`: 1 selects the narrow tracking bandwidth and 0 selects the wide acquisition bandwidth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 1 | One-cycle pulse per divided reference period |
| fb_pulse | input | 1 | One-cycle pulse per divided VCO feedback period |
| auto_en | input | 1 | 1 = automatic bandwidth control |
| manual_trk | input | 1 | Requested mode when automatic control is off (1 = tracking) |
| irq_en | input | 1 | Enables interrupt requests on lock changes |
| irq_ack | input | 1 | One-cycle clear of the pending request |
| trk_mode | output | 1 | Mode flag: 0 acquisition, 1 tracking |
| locked | output | 1 | Lock flag |
| bw_narrow | output | 1 | Loop-filter bandwidth select, 1 = narrow |
| irq | output | 1 | Pending interrupt request |

## Verification
The bench builds the detector with a 16-pulse window and the default thresholds (2/4 for mode, 1/3 for lock). A window then lasts only 64 cycles, so every ordered pair of feedback counts from 10 to 22 can be run back to back. That sweep crosses every entry threshold, exit threshold and hold band from each reachable flag state, and it also exercises the lock gating on the previous mode. Short directed runs then cover manual mode, the suppressed interrupt and the acknowledge.

// File: rtl/pll_ld_pkg.sv
package pll_ld_pkg;

   // Width of the feedback counter: holds up to twice the window length plus headroom.
   function automatic int unsigned fb_cnt_width(input int unsigned win_refs);
      return $clog2(2 * win_refs + 2);
   endfunction

   // Width of the reference counter: counts 0 .. win_refs-1.
   function automatic int unsigned ref_cnt_width(input int unsigned win_refs);
      return (win_refs > 1) ? $clog2(win_refs) : 1;
   endfunction

   typedef enum logic {
      MODE_ACQ = 1'b0,
      MODE_TRK = 1'b1
   } filt_mode_e;

endpackage

// File: rtl/pll_freq_window.sv
module pll_freq_window
   import pll_ld_pkg::*;
#(
   parameter int unsigned WIN_REFS = 64,
   parameter int unsigned CW       = fb_cnt_width(WIN_REFS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ref_pulse,
   input  logic          fb_pulse,
   output logic          done,
   output logic [CW-1:0] err
);

   localparam int unsigned RW = ref_cnt_width(WIN_REFS);
   localparam logic [RW-1:0] REF_LAST = RW'(WIN_REFS - 1);
   localparam logic [CW-1:0] WIN_LEN  = CW'(WIN_REFS);
   localparam logic [CW-1:0] FB_MAX   = '1;

   if (WIN_REFS < 2) begin : g_bad_win
      $error("pll_freq_window: WIN_REFS must be at least 2");
   end

   logic [RW-1:0] ref_cnt;
   logic [CW-1:0] fb_cnt;
   logic [CW-1:0] fb_total;
   logic [CW-1:0] err_c;
   logic          close_win;

   assign close_win = ref_pulse && (ref_cnt == REF_LAST);

   // Feedback count including this cycle, saturating so a runaway VCO
   // still yields a large (not wrapped) error.
   always_comb begin
      fb_total = fb_cnt;
      if (fb_pulse && (fb_cnt != FB_MAX)) begin
         fb_total = fb_cnt + 1'b1;
      end
   end

   always_comb begin
      if (fb_total >= WIN_LEN) begin
         err_c = fb_total - WIN_LEN;
      end else begin
         err_c = WIN_LEN - fb_total;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_cnt <= '0;
         fb_cnt  <= '0;
         done    <= 1'b0;
         err     <= '0;
      end else begin
         done <= close_win;
         if (close_win) begin
            ref_cnt <= '0;
            fb_cnt  <= '0;
            err     <= err_c;
         end else begin
            if (ref_pulse) begin
               ref_cnt <= ref_cnt + 1'b1;
            end
            fb_cnt <= fb_total;
         end
      end
   end

endmodule

// File: rtl/pll_hyst_flag.sv
module pll_hyst_flag #(
   parameter int unsigned CW    = 8,
   parameter int unsigned ENTER = 2,
   parameter int unsigned EXIT  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done,
   input  logic [CW-1:0] err,
   input  logic          allow_set,
   input  logic          force_en,
   input  logic          force_val,
   output logic          flag
);

   if (EXIT <= ENTER) begin : g_bad_band
      $error("pll_hyst_flag: EXIT must exceed ENTER");
   end
   if (EXIT >= (1 << CW)) begin : g_bad_width
      $error("pll_hyst_flag: EXIT does not fit the error width");
   end

   localparam logic [CW-1:0] ENTER_C = CW'(ENTER);
   localparam logic [CW-1:0] EXIT_C  = CW'(EXIT);

   logic in_band;
   logic out_band;

   assign in_band  = (err <= ENTER_C);
   assign out_band = (err >  EXIT_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (force_en) begin
         flag <= force_val;
      end else if (done) begin
         if (in_band && allow_set) begin
            flag <= 1'b1;
         end else if (out_band) begin
            flag <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pll_lock_irq.sv
module pll_lock_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic lock,
   input  logic irq_en,
   input  logic irq_ack,
   output logic irq
);

   logic lock_d;
   logic lock_chg;

   assign lock_chg = lock ^ lock_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_d <= 1'b0;
         irq    <= 1'b0;
      end else begin
         lock_d <= lock;
         if (irq_en && lock_chg) begin
            irq <= 1'b1;
         end else if (irq_ack) begin
            irq <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pll_lock_bw_detect.sv
module pll_lock_bw_detect
   import pll_ld_pkg::*;
#(
   parameter int unsigned WIN_REFS   = 64,
   parameter int unsigned TRK_ENTER  = 2,
   parameter int unsigned TRK_EXIT   = 4,
   parameter int unsigned LOCK_ENTER = 1,
   parameter int unsigned UNLOCK     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_pulse,
   input  logic fb_pulse,
   input  logic auto_en,
   input  logic manual_trk,
   input  logic irq_en,
   input  logic irq_ack,
   output logic trk_mode,
   output logic locked,
   output logic bw_narrow,
   output logic irq
);

   localparam int unsigned CW = fb_cnt_width(WIN_REFS);

   logic          win_done;
   logic [CW-1:0] win_err;
   logic          lock_allow;
   filt_mode_e    mode_q;

   pll_freq_window #(
      .WIN_REFS (WIN_REFS),
      .CW       (CW)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_pulse (ref_pulse),
      .fb_pulse  (fb_pulse),
      .done      (win_done),
      .err       (win_err)
   );

   pll_hyst_flag #(
      .CW    (CW),
      .ENTER (TRK_ENTER),
      .EXIT  (TRK_EXIT)
   ) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (win_done),
      .err       (win_err),
      .allow_set (1'b1),
      .force_en  (!auto_en),
      .force_val (manual_trk),
      .flag      (trk_mode)
   );

   // In automatic mode lock may only be declared once tracking is established.
   assign lock_allow = auto_en ? trk_mode : 1'b1;

   pll_hyst_flag #(
      .CW    (CW),
      .ENTER (LOCK_ENTER),
      .EXIT  (UNLOCK)
   ) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (win_done),
      .err       (win_err),
      .allow_set (lock_allow),
      .force_en  (1'b0),
      .force_val (1'b0),
      .flag      (locked)
   );

   pll_lock_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock    (locked),
      .irq_en  (irq_en),
      .irq_ack (irq_ack),
      .irq     (irq)
   );

   assign mode_q    = filt_mode_e'(trk_mode);
   assign bw_narrow = (mode_q == MODE_TRK);

endmodule

// File: rtl/pll_lock_bw_detect_chk.sv
module pll_lock_bw_detect_chk #(
   parameter int unsigned CW         = 8,
   parameter int unsigned TRK_ENTER  = 2,
   parameter int unsigned TRK_EXIT   = 4,
   parameter int unsigned LOCK_ENTER = 1,
   parameter int unsigned UNLOCK     = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          auto_en,
   input logic          irq_en,
   input logic          irq_ack,
   input logic          trk_mode,
   input logic          locked,
   input logic          irq,
   input logic          win_done,
   input logic [CW-1:0] win_err
);

   localparam logic [CW-1:0] TE = CW'(TRK_ENTER);
   localparam logic [CW-1:0] TX = CW'(TRK_EXIT);
   localparam logic [CW-1:0] LE = CW'(LOCK_ENTER);
   localparam logic [CW-1:0] LX = CW'(UNLOCK);

   // R3: automatic entry into tracking only after a window inside the entry band
   a_r3_trk_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(trk_mode) && $past(auto_en)) |-> $past(win_done && (win_err <= TE)));

   // R4: automatic exit from tracking only after a window beyond the exit band
   a_r4_trk_fall: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(trk_mode) && $past(auto_en)) |-> $past(win_done && (win_err > TX)));

   // R5: lock set needs an in-band window and, in automatic mode, prior tracking
   a_r5_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(win_done && (win_err <= LE) && (trk_mode || !auto_en)));

   // R6: lock clears only after a window beyond the unlock band
   a_r6_lock_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(win_done && (win_err > LX)));

   // R7: a lock change with interrupts enabled raises the request
   a_r7_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && (locked != $past(locked))) |=> irq);

   // R8: the request only drops on an acknowledge
   a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(irq_ack));

endmodule

bind pll_lock_bw_detect pll_lock_bw_detect_chk #(
   .CW         (CW),
   .TRK_ENTER  (TRK_ENTER),
   .TRK_EXIT   (TRK_EXIT),
   .LOCK_ENTER (LOCK_ENTER),
   .UNLOCK     (UNLOCK)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .auto_en  (auto_en),
   .irq_en   (irq_en),
   .irq_ack  (irq_ack),
   .trk_mode (trk_mode),
   .locked   (locked),
   .irq      (irq),
   .win_done (win_done),
   .win_err  (win_err)
);

// File: tb/pll_lock_bw_detect_tb.sv
module pll_lock_bw_detect_tb;

   localparam int NW  = 16;
   localparam int TEN = 2;
   localparam int TEX = 4;
   localparam int LEN = 1;
   localparam int LEX = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_pulse = 1'b0;
   logic fb_pulse = 1'b0;
   logic auto_en = 1'b1;
   logic manual_trk = 1'b0;
   logic irq_en = 1'b1;
   logic irq_ack = 1'b0;
   logic trk_mode, locked, bw_narrow, irq;

   int checks = 0;
   int errors = 0;

   // model state
   logic m_trk = 1'b0;
   logic m_lock = 1'b0;
   logic m_irq = 1'b0;

   always #2 clk = ~clk;

   pll_lock_bw_detect #(
      .WIN_REFS (NW), .TRK_ENTER (TEN), .TRK_EXIT (TEX),
      .LOCK_ENTER (LEN), .UNLOCK (LEX)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .ref_pulse (ref_pulse), .fb_pulse (fb_pulse),
      .auto_en (auto_en), .manual_trk (manual_trk), .irq_en (irq_en),
      .irq_ack (irq_ack), .trk_mode (trk_mode), .locked (locked),
      .bw_narrow (bw_narrow), .irq (irq)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_trk = 1'b0; m_lock = 1'b0; m_irq = 1'b0;
      @(negedge clk);
   endtask

   // R2: one window of NW reference pulses with nfb feedback pulses, then model update
   task automatic run_window(input int nfb);
      int e;
      logic old_lock;
      for (int k = 0; k < 4 * NW; k++) begin
         @(negedge clk);
         ref_pulse = ((k % 4) == 3);
         fb_pulse  = (k < nfb);
      end
      @(negedge clk);
      ref_pulse = 1'b0;
      fb_pulse  = 1'b0;
      repeat (4) @(negedge clk);
      e = (nfb > NW) ? nfb - NW : NW - nfb;
      old_lock = m_lock;
      if (e <= LEN && (m_trk || !auto_en)) m_lock = 1'b1;
      else if (e > LEX) m_lock = 1'b0;
      if (auto_en) begin
         if (e <= TEN) m_trk = 1'b1;
         else if (e > TEX) m_trk = 1'b0;
      end
      if (irq_en && (old_lock != m_lock)) m_irq = 1'b1;
   endtask

   task automatic check_all(input string tag);
      chk(trk_mode, m_trk, {"R3/R4 trk ", tag});
      chk(locked, m_lock, {"R5/R6 lock ", tag});
      chk(bw_narrow, m_trk, {"R10 bw ", tag});
      chk(irq, m_irq, {"R7 irq ", tag});
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      m_irq = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset values
      chk(trk_mode, 1'b0, "R1 trk");
      chk(locked, 1'b0, "R1 lock");
      chk(bw_narrow, 1'b0, "R1 bw");
      chk(irq, 1'b0, "R1 irq");

      // R2 R3 R4 R5 R6 R7: every ordered pair of feedback counts NW-6..NW+6
      for (int a = -6; a <= 6; a++) begin
         for (int b = -6; b <= 6; b++) begin
            run_window(NW + a);
            check_all("sweep a");
            run_window(NW + b);
            check_all("sweep b");
            if (m_irq) begin
               repeat (5) @(negedge clk);
               chk(irq, 1'b1, "R8 irq held before ack");
               ack();
               chk(irq, 1'b0, "R8 irq cleared by ack");
            end
         end
      end

      // R5 gating: exact frequency from acquisition sets trk but not lock
      do_reset();
      run_window(NW);
      chk(trk_mode, 1'b1, "R3 trk from exact window");
      chk(locked, 1'b0, "R5 lock gated by prior trk");
      run_window(NW);
      chk(locked, 1'b1, "R5 lock on second window");
      chk(irq, 1'b1, "R7 irq on lock rise");
      ack();

      // R9 manual mode
      do_reset();
      auto_en = 1'b0;
      manual_trk = 1'b0;
      irq_en = 1'b0;
      run_window(NW);
      chk(trk_mode, 1'b0, "R9 manual trk ignores window");
      chk(locked, 1'b1, "R9 lock ungated in manual");
      chk(irq, 1'b0, "R7 no irq when disabled");
      run_window(NW - 6);
      chk(locked, 1'b0, "R6 unlock in manual");
      chk(irq, 1'b0, "R7 no irq on fall when disabled");
      manual_trk = 1'b1;
      @(negedge clk);
      chk(trk_mode, 1'b1, "R9 trk follows request");
      chk(bw_narrow, 1'b1, "R10 bw follows trk");
      run_window(NW + 6);
      chk(trk_mode, 1'b1, "R9 large error leaves manual trk");
      manual_trk = 1'b0;
      @(negedge clk);
      chk(trk_mode, 1'b0, "R9 trk drops with request");
      chk(bw_narrow, 1'b0, "R10 bw wide");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule